// File: doc/BRIEF.md
# Collective Copy Instruction Validator

This block takes one 64-byte instruction word for a buffer-to-buffer collective copy and decides whether every field in it is legal. The word is presented in one of two ways. It can arrive whole on a wide parallel input. It can also arrive as sixteen 32-bit beats on a valid/ready stream. In that case beat 0 carries bytes 0..3, and byte 0 sits in the low eight bits of each beat. A beat is accepted on any cycle where both valid and ready are high.

For each word the block registers three things:

- a pass flag;
- an error vector with one bit per rule class, so several bits may be set at once;
- the fields decoded from the word: the header bytes, the event/semaphore controls, the data type, the group format, the channel count, and both three-dimensional tensor descriptors with their element-count products.

Register-based tensor addresses are decoded but rejected as unsupported. The block does not execute the copy and does not compare the semaphore with any live state.

Top module: `coll_copy_validator`

## Requirements
- R1: Byte 0 must equal 0xBF; any other value sets error bit 0.
- R2: Bytes 12 (input type) and 13 (output type) must each hold a code in 1..15; a code of 0 or above 15 in either sets bit 1. Unequal codes set bit 2.
- R3: Bytes 14..15 and 34..47 must all be zero; any set bit there sets error bit 3.
- R4: Byte 32 (group format: 0 self, 1 pairs, 2 fours, 3 eights) must be 0 or 1; any larger value sets bit 4.
- R5: Byte 33 (active channels) must be in 1..128; otherwise bit 5 is set.
- R6: Each tensor is a 4-byte base, then three signed 16-bit strides, then three unsigned 16-bit counts, all little-endian. The source tensor occupies bytes 16..31 and the destination tensor bytes 48..63. A zero count in the source sets bit 6; a zero count in the destination sets bit 7.
- R7: The product of the three source counts must not exceed 256, or bit 8 is set. The destination product is reported but not capped.
- R8: When address bits 31:30 are 00 (immediate mode), address bit 25 must be 0 (state buffer). Violation sets bit 9 for the source and bit 10 for the destination.
- R9: Address bits 31:30 other than 00 mean register mode (10 address register, 01 shape register, 11 both). The mode is reported on the mode output and sets bit 11 for the source or bit 12 for the destination. Bit 25 is not judged in register mode.
- R10: A word presented with par_valid gives res_valid for exactly one cycle, on the next clock. res_pass is high exactly when the error vector is zero. The decoded outputs carry the fields of that word: the header (bytes 1..3), wait mode (byte 4), wait index (byte 5), update mode (byte 6), update index (byte 7) and the 32-bit semaphore (bytes 8..11), alongside the data type, group, channel and tensor outputs.
- R11: In streamed form, the result of a word appears one cycle after its beat 15 is accepted. The first beat of the next word may be accepted on the following cycle.
- R12: While par_valid is high, beat_ready is low and no beat is consumed; the stream resumes intact afterwards.
- R13: During and right after reset, res_valid is low, beat_ready is high and the beat position is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_valid | input | 1 | Whole word present on par_word |
| par_word | input | 512 | Instruction word, byte k at bits 8k+7:8k |
| beat_valid | input | 1 | Stream beat present |
| beat_data | input | 32 | Stream beat, lowest byte first |
| beat_ready | output | 1 | Stream beat can be accepted |
| res_valid | output | 1 | Result pulse |
| res_pass | output | 1 | Word passes all rules |
| res_err | output | 13 | One bit per violated rule class |
| out_hdr | output | 24 | Bytes 3..1 (hint, command, length) |
| out_wait_mode | output | 8 | Wait mode |
| out_wait_idx | output | 8 | Wait index |
| out_upd_mode | output | 8 | Update mode |
| out_upd_idx | output | 8 | Update index |
| out_sem | output | 32 | Semaphore value |
| out_dtype | output | 8 | Input data type code |
| out_grp | output | 8 | Group format |
| out_chans | output | 8 | Active channel count |
| src_base | output | 32 | Source base address |
| src_mode | output | 2 | Source address mode (bits 31:30) |
| src_steps | output | 48 | Source strides, dimension 0 lowest |
| src_counts | output | 48 | Source counts, dimension 0 lowest |
| src_elems | output | 48 | Product of source counts |
| dst_base | output | 32 | Destination base address |
| dst_mode | output | 2 | Destination address mode |
| dst_steps | output | 48 | Destination strides |
| dst_counts | output | 48 | Destination counts |
| dst_elems | output | 48 | Product of destination counts |

## Verification
The vector table starts from a legal word and changes one byte at a time. Each variant is sent both whole and as beats, so a byte-ordering fault in the beat path shows up as a mismatch between the two forms.

The variants sit on both sides of each limit:

- channel counts 0, 128 and 129;
- source products of 256 and 272;
- a count whose high byte alone breaks the cap;
- a large destination product that must stay legal.

They also separate the cases the rules distinguish:

- the address-space bit against a nearby bit that carries no rule;
- register modes with and without that bit set;
- a bad type code against a plain mismatch.

Directed tests cover back-to-back streamed words and a parallel word arriving in the middle of a stream.

// File: rtl/ccv_pkg.sv
package ccv_pkg;
  localparam int WORD_BYTES = 64;
  localparam int WORD_W     = WORD_BYTES * 8;
  localparam int DIMS       = 3;
  localparam int CNT_W      = 16;
  localparam int ELEM_W     = CNT_W * DIMS;
  localparam int TENS_BYTES = 16;
  localparam int TENS_W     = TENS_BYTES * 8;
  localparam int SPACE_BIT  = 25;
  localparam logic [7:0] OPC_COPY    = 8'hBF;
  localparam logic [7:0] DT_MAX      = 8'd15;
  localparam logic [7:0] GRP_LAST_OK = 8'd1;

  // error vector positions
  localparam int E_OPCODE   = 0;
  localparam int E_DT_CODE  = 1;
  localparam int E_DT_DIFF  = 2;
  localparam int E_RSVD     = 3;
  localparam int E_GROUP    = 4;
  localparam int E_CHANS    = 5;
  localparam int E_SRC_ZERO = 6;
  localparam int E_DST_ZERO = 7;
  localparam int E_SRC_BIG  = 8;
  localparam int E_SRC_SPC  = 9;
  localparam int E_DST_SPC  = 10;
  localparam int E_SRC_REG  = 11;
  localparam int E_DST_REG  = 12;
  localparam int ERR_W      = 13;

  typedef struct packed {
    logic [31:0]       base;
    logic [1:0]        mode;
    logic [ELEM_W-1:0] steps;
    logic [ELEM_W-1:0] counts;
    logic [ELEM_W-1:0] elems;
  } tens_t;

  typedef struct packed {
    logic [23:0] hdr;
    logic [7:0]  wmode;
    logic [7:0]  widx;
    logic [7:0]  umode;
    logic [7:0]  uidx;
    logic [31:0] sem;
    logic [7:0]  dtype;
    logic [7:0]  grp;
    logic [7:0]  chans;
    tens_t       src;
    tens_t       dst;
  } dec_t;

  function automatic logic [7:0] byte_at(input logic [WORD_W-1:0] w, input int k);
    return w[8*k +: 8];
  endfunction

  function automatic logic [ELEM_W-1:0] dim_product(input logic [ELEM_W-1:0] cnts);
    logic [ELEM_W-1:0] p;
    p = ELEM_W'(1);
    for (int d = 0; d < DIMS; d++) p = p * ELEM_W'(cnts[d*CNT_W +: CNT_W]);
    return p;
  endfunction

  function automatic logic dtype_code_ok(input logic [7:0] d);
    return (d != 8'd0) && (d <= DT_MAX);
  endfunction
endpackage

// File: rtl/ccv_beat_collect.sv
module ccv_beat_collect
  import ccv_pkg::*;
#(
  parameter int BEAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              beat_valid,
  input  logic [BEAT_W-1:0] beat_data,
  output logic              beat_ready,
  output logic [WORD_W-1:0] word,
  output logic              done
);
  localparam int NB    = WORD_W / BEAT_W;
  localparam int IDX_W = $clog2(NB);
  localparam int ST_W  = BEAT_W * (NB - 1);

  logic [IDX_W-1:0] idx;
  logic [ST_W-1:0]  store;
  logic             accept;

  assign beat_ready = !hold;
  assign accept     = beat_valid && beat_ready;
  assign done       = accept && (idx == IDX_W'(NB - 1));
  assign word       = {beat_data, store};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (accept) begin
      idx <= done ? '0 : idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store <= '0;
    end else if (accept && !done) begin
      store[idx*BEAT_W +: BEAT_W] <= beat_data;
    end
  end
endmodule

// File: rtl/ccv_tensor_check.sv
module ccv_tensor_check
  import ccv_pkg::*;
#(
  parameter int MAX_ELEMS = 256,
  parameter bit CAP_SIZE  = 1'b1
) (
  input  logic [TENS_W-1:0] raw,
  output tens_t             t,
  output logic              zero_dim,
  output logic              too_big,
  output logic              not_sbuf,
  output logic              reg_mode
);
  logic [DIMS-1:0] dim_empty;

  assign t.base   = raw[31:0];
  assign t.mode   = raw[31:30];
  assign t.steps  = raw[32 +: ELEM_W];
  assign t.counts = raw[32+ELEM_W +: ELEM_W];
  assign t.elems  = dim_product(t.counts);

  for (genvar d = 0; d < DIMS; d++) begin : g_dim
    assign dim_empty[d] = (t.counts[d*CNT_W +: CNT_W] == '0);
  end
  assign zero_dim = |dim_empty;

  if (CAP_SIZE) begin : g_cap
    assign too_big = t.elems > ELEM_W'(MAX_ELEMS);
  end else begin : g_nocap
    assign too_big = 1'b0;
  end

  assign reg_mode = (t.mode != 2'b00);
  assign not_sbuf = !reg_mode && t.base[SPACE_BIT];
endmodule

// File: rtl/ccv_field_check.sv
module ccv_field_check
  import ccv_pkg::*;
#(
  parameter int MAX_ELEMS = 256,
  parameter int MAX_CHANS = 128
) (
  input  logic [WORD_W-1:0] word,
  output logic [ERR_W-1:0]  err,
  output dec_t              dec
);
  localparam int SRC_OFS = 16;
  localparam int DST_OFS = 48;

  logic s_zero, s_big, s_spc, s_reg;
  logic d_zero, d_big, d_spc, d_reg;
  logic [7:0] dt_in, dt_out;
  logic       rsvd_dirty;

  ccv_tensor_check #(.MAX_ELEMS(MAX_ELEMS), .CAP_SIZE(1'b1)) src_chk_i (
    .raw(word[8*SRC_OFS +: TENS_W]), .t(dec.src),
    .zero_dim(s_zero), .too_big(s_big), .not_sbuf(s_spc), .reg_mode(s_reg));

  ccv_tensor_check #(.MAX_ELEMS(MAX_ELEMS), .CAP_SIZE(1'b0)) dst_chk_i (
    .raw(word[8*DST_OFS +: TENS_W]), .t(dec.dst),
    .zero_dim(d_zero), .too_big(d_big), .not_sbuf(d_spc), .reg_mode(d_reg));

  assign dt_in  = byte_at(word, 12);
  assign dt_out = byte_at(word, 13);

  assign dec.hdr   = word[31:8];
  assign dec.wmode = byte_at(word, 4);
  assign dec.widx  = byte_at(word, 5);
  assign dec.umode = byte_at(word, 6);
  assign dec.uidx  = byte_at(word, 7);
  assign dec.sem   = word[64 +: 32];
  assign dec.dtype = dt_in;
  assign dec.grp   = byte_at(word, 32);
  assign dec.chans = byte_at(word, 33);

  assign rsvd_dirty = (|word[8*14 +: 16]) || (|word[8*34 +: 8*14]);

  always_comb begin
    err             = '0;
    err[E_OPCODE]   = byte_at(word, 0) != OPC_COPY;
    err[E_DT_CODE]  = !dtype_code_ok(dt_in) || !dtype_code_ok(dt_out);
    err[E_DT_DIFF]  = dt_in != dt_out;
    err[E_RSVD]     = rsvd_dirty;
    err[E_GROUP]    = dec.grp > GRP_LAST_OK;
    err[E_CHANS]    = (dec.chans == 8'd0) || (32'(dec.chans) > MAX_CHANS);
    err[E_SRC_ZERO] = s_zero;
    err[E_DST_ZERO] = d_zero;
    err[E_SRC_BIG]  = s_big | d_big;
    err[E_SRC_SPC]  = s_spc;
    err[E_DST_SPC]  = d_spc;
    err[E_SRC_REG]  = s_reg;
    err[E_DST_REG]  = d_reg;
  end
endmodule

// File: rtl/coll_copy_validator.sv
module coll_copy_validator
  import ccv_pkg::*;
#(
  parameter int BEAT_W    = 32,
  parameter int MAX_ELEMS = 256,
  parameter int MAX_CHANS = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 par_valid,
  input  logic [WORD_W-1:0]    par_word,
  input  logic                 beat_valid,
  input  logic [BEAT_W-1:0]    beat_data,
  output logic                 beat_ready,
  output logic                 res_valid,
  output logic                 res_pass,
  output logic [ERR_W-1:0]     res_err,
  output logic [23:0]          out_hdr,
  output logic [7:0]           out_wait_mode,
  output logic [7:0]           out_wait_idx,
  output logic [7:0]           out_upd_mode,
  output logic [7:0]           out_upd_idx,
  output logic [31:0]          out_sem,
  output logic [7:0]           out_dtype,
  output logic [7:0]           out_grp,
  output logic [7:0]           out_chans,
  output logic [31:0]          src_base,
  output logic [1:0]           src_mode,
  output logic [ELEM_W-1:0]    src_steps,
  output logic [ELEM_W-1:0]    src_counts,
  output logic [ELEM_W-1:0]    src_elems,
  output logic [31:0]          dst_base,
  output logic [1:0]           dst_mode,
  output logic [ELEM_W-1:0]    dst_steps,
  output logic [ELEM_W-1:0]    dst_counts,
  output logic [ELEM_W-1:0]    dst_elems
);
  logic [WORD_W-1:0] stream_word, chk_word;
  logic              stream_done, take;
  logic [ERR_W-1:0]  err_now;
  dec_t              dec_now, dec_q;

  ccv_beat_collect #(.BEAT_W(BEAT_W)) collect_i (
    .clk(clk), .rst_n(rst_n), .hold(par_valid),
    .beat_valid(beat_valid), .beat_data(beat_data), .beat_ready(beat_ready),
    .word(stream_word), .done(stream_done));

  assign take     = par_valid || stream_done;
  assign chk_word = par_valid ? par_word : stream_word;

  ccv_field_check #(.MAX_ELEMS(MAX_ELEMS), .MAX_CHANS(MAX_CHANS)) fields_i (
    .word(chk_word), .err(err_now), .dec(dec_now));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
      res_err   <= '0;
      dec_q     <= '0;
    end else begin
      res_valid <= take;
      if (take) begin
        res_pass <= (err_now == '0);
        res_err  <= err_now;
        dec_q    <= dec_now;
      end
    end
  end

  assign out_hdr       = dec_q.hdr;
  assign out_wait_mode = dec_q.wmode;
  assign out_wait_idx  = dec_q.widx;
  assign out_upd_mode  = dec_q.umode;
  assign out_upd_idx   = dec_q.uidx;
  assign out_sem       = dec_q.sem;
  assign out_dtype     = dec_q.dtype;
  assign out_grp       = dec_q.grp;
  assign out_chans     = dec_q.chans;
  assign src_base      = dec_q.src.base;
  assign src_mode      = dec_q.src.mode;
  assign src_steps     = dec_q.src.steps;
  assign src_counts    = dec_q.src.counts;
  assign src_elems     = dec_q.src.elems;
  assign dst_base      = dec_q.dst.base;
  assign dst_mode      = dec_q.dst.mode;
  assign dst_steps     = dec_q.dst.steps;
  assign dst_counts    = dec_q.dst.counts;
  assign dst_elems     = dec_q.dst.elems;
endmodule

// File: rtl/coll_copy_validator_chk.sv
module coll_copy_validator_chk
  import ccv_pkg::*;
#(
  parameter int MAX_ELEMS = 256,
  parameter int MAX_CHANS = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              par_valid,
  input logic              beat_ready,
  input logic              stream_done,
  input logic              take,
  input logic              res_valid,
  input logic              res_pass,
  input logic [7:0]        out_grp,
  input logic [7:0]        out_chans,
  input logic [7:0]        out_dtype,
  input logic [ELEM_W-1:0] src_elems
);
  assert_par_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid |-> !beat_ready);

  assert_par_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid |=> res_valid);

  assert_stream_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stream_done |=> res_valid);

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(take));

  assert_group_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pass) |-> (out_grp <= 8'd1));

  assert_chan_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pass) |-> (out_chans != 8'd0 && 32'(out_chans) <= MAX_CHANS));

  assert_size_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pass) |-> (src_elems <= ELEM_W'(MAX_ELEMS)));

  assert_dtype_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pass) |-> (out_dtype != 8'd0 && out_dtype <= 8'd15));
endmodule

bind coll_copy_validator coll_copy_validator_chk #(.MAX_ELEMS(MAX_ELEMS), .MAX_CHANS(MAX_CHANS)) chk_i (
  .clk(clk), .rst_n(rst_n), .par_valid(par_valid), .beat_ready(beat_ready),
  .stream_done(stream_done), .take(take), .res_valid(res_valid), .res_pass(res_pass),
  .out_grp(out_grp), .out_chans(out_chans), .out_dtype(out_dtype), .src_elems(src_elems));

// File: tb/coll_copy_validator_tb_top.sv
`timescale 1ns/1ps
module coll_copy_validator_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         par_valid = 1'b0;
  logic [511:0] par_word = '0;
  logic         beat_valid = 1'b0;
  logic [31:0]  beat_data = '0;
  logic         beat_ready, res_valid, res_pass;
  logic [12:0]  res_err;
  logic [23:0]  out_hdr;
  logic [7:0]   out_wait_mode, out_wait_idx, out_upd_mode, out_upd_idx;
  logic [31:0]  out_sem;
  logic [7:0]   out_dtype, out_grp, out_chans;
  logic [31:0]  src_base, dst_base;
  logic [1:0]   src_mode, dst_mode;
  logic [47:0]  src_steps, src_counts, src_elems, dst_steps, dst_counts, dst_elems;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  coll_copy_validator dut_i (
    .clk(clk), .rst_n(rst_n), .par_valid(par_valid), .par_word(par_word),
    .beat_valid(beat_valid), .beat_data(beat_data), .beat_ready(beat_ready),
    .res_valid(res_valid), .res_pass(res_pass), .res_err(res_err), .out_hdr(out_hdr),
    .out_wait_mode(out_wait_mode), .out_wait_idx(out_wait_idx),
    .out_upd_mode(out_upd_mode), .out_upd_idx(out_upd_idx), .out_sem(out_sem),
    .out_dtype(out_dtype), .out_grp(out_grp), .out_chans(out_chans),
    .src_base(src_base), .src_mode(src_mode), .src_steps(src_steps),
    .src_counts(src_counts), .src_elems(src_elems),
    .dst_base(dst_base), .dst_mode(dst_mode), .dst_steps(dst_steps),
    .dst_counts(dst_counts), .dst_elems(dst_elems));

  typedef struct packed {
    logic [7:0]  idx;
    logic [7:0]  val;
    logic [12:0] err;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{8'd0,  8'hBF, 13'h0000, 8'd10}, // R10 legal word
    '{8'd0,  8'hBE, 13'h0001, 8'd1},  // R1
    '{8'd0,  8'h3F, 13'h0001, 8'd1},  // R1
    '{8'd12, 8'd0,  13'h0006, 8'd2},  // R2 invalid code + mismatch
    '{8'd13, 8'd11, 13'h0004, 8'd2},  // R2 mismatch
    '{8'd12, 8'd16, 13'h0006, 8'd2},  // R2 code above 15
    '{8'd13, 8'd15, 13'h0004, 8'd2},  // R2
    '{8'd1,  8'd5,  13'h0000, 8'd10}, // R10 header byte unchecked
    '{8'd14, 8'd1,  13'h0008, 8'd3},  // R3
    '{8'd15, 8'h80, 13'h0008, 8'd3},  // R3
    '{8'd34, 8'd1,  13'h0008, 8'd3},  // R3
    '{8'd47, 8'h80, 13'h0008, 8'd3},  // R3
    '{8'd32, 8'd0,  13'h0000, 8'd4},  // R4 self
    '{8'd32, 8'd2,  13'h0010, 8'd4},  // R4
    '{8'd32, 8'd3,  13'h0010, 8'd4},  // R4
    '{8'd33, 8'd0,  13'h0020, 8'd5},  // R5
    '{8'd33, 8'd128,13'h0000, 8'd5},  // R5 upper edge
    '{8'd33, 8'd129,13'h0020, 8'd5},  // R5
    '{8'd26, 8'd0,  13'h0040, 8'd6},  // R6 src zero count
    '{8'd62, 8'd0,  13'h0080, 8'd6},  // R6 dst zero count
    '{8'd30, 8'd16, 13'h0000, 8'd7},  // R7 exactly 256
    '{8'd30, 8'd17, 13'h0100, 8'd7},  // R7 272
    '{8'd27, 8'd1,  13'h0100, 8'd7},  // R7 high byte count 260
    '{8'd58, 8'hFF, 13'h0000, 8'd7},  // R7 dst product not capped
    '{8'd19, 8'h02, 13'h0200, 8'd8},  // R8 src bit 25
    '{8'd51, 8'h02, 13'h0400, 8'd8},  // R8 dst bit 25
    '{8'd18, 8'h02, 13'h0000, 8'd8},  // R8 bit 17 is free
    '{8'd19, 8'h80, 13'h0800, 8'd9},  // R9 src addr reg
    '{8'd19, 8'h82, 13'h0800, 8'd9},  // R9 bit 25 not judged
    '{8'd51, 8'h40, 13'h1000, 8'd9},  // R9 dst shape reg
    '{8'd51, 8'hC0, 13'h1000, 8'd9}   // R9 dst both
  };

  function automatic logic [511:0] put16(input logic [511:0] w, input int k, input logic [15:0] v);
    logic [511:0] r;
    r = w;
    r[8*k +: 16] = v;
    return r;
  endfunction

  function automatic logic [511:0] base_word();
    logic [511:0] w;
    w = '0;
    w[7:0] = 8'hBF; w[15:8] = 8'd16;
    w[39:32] = 8'd1; w[47:40] = 8'd2; w[55:48] = 8'd3; w[63:56] = 8'd4;
    w[95:64] = 32'h11223344;
    w[103:96] = 8'd10; w[111:104] = 8'd10;
    w[8*16 +: 32] = 32'h0000_1000;
    w = put16(w, 20, 16'd1); w = put16(w, 22, 16'd4); w = put16(w, 24, 16'd16);
    w = put16(w, 26, 16'd4); w = put16(w, 28, 16'd4); w = put16(w, 30, 16'd4);
    w[8*32 +: 8] = 8'd1; w[8*33 +: 8] = 8'd8;
    w[8*48 +: 32] = 32'h0000_2000;
    w = put16(w, 52, 16'd1); w = put16(w, 54, 16'd2); w = put16(w, 56, 16'd3);
    w = put16(w, 58, 16'd2); w = put16(w, 60, 16'd2); w = put16(w, 62, 16'd2);
    return w;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_par(input logic [511:0] w);
    @(negedge clk);
    par_valid = 1'b1;
    par_word  = w;
    @(posedge clk);
    #1;
    par_valid = 1'b0;
  endtask

  task automatic send_beats(input logic [511:0] w, input int lo, input int hi);
    for (int b = lo; b <= hi; b++) begin
      @(negedge clk);
      beat_valid = 1'b1;
      beat_data  = w[32*b +: 32];
      @(posedge clk);
    end
    #1;
  endtask

  task automatic check_result(input string req, input logic [12:0] exp);
    chk(req, "res_valid", 64'(res_valid), 64'd1);
    chk(req, "res_err", 64'(res_err), 64'(exp));
    chk(req, "res_pass", 64'(res_pass), 64'(exp == 13'd0));
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [511:0] w, bad;
    // R13 reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R13", "res_valid in reset", 64'(res_valid), 64'd0);
    chk("R13", "beat_ready in reset", 64'(beat_ready), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R13", "res_valid after reset", 64'(res_valid), 64'd0);

    // table: parallel then streamed for each vector
    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[i].req);
      w = base_word();
      w[8*VECS[i].idx +: 8] = VECS[i].val;
      send_par(w);
      check_result({rq, "/par"}, VECS[i].err);
      send_beats(w, 0, 15);
      check_result({rq, "/stream R11"}, VECS[i].err);
      @(negedge clk);
      beat_valid = 1'b0;
    end

    // R10 decoded fields and single-cycle pulse
    w = base_word();
    send_par(w);
    chk("R10", "hdr", 64'(out_hdr), 64'h000010);
    chk("R10", "wait_mode", 64'(out_wait_mode), 64'd1);
    chk("R10", "wait_idx", 64'(out_wait_idx), 64'd2);
    chk("R10", "upd_mode", 64'(out_upd_mode), 64'd3);
    chk("R10", "upd_idx", 64'(out_upd_idx), 64'd4);
    chk("R10", "sem", 64'(out_sem), 64'h11223344);
    chk("R10", "dtype", 64'(out_dtype), 64'd10);
    chk("R10", "grp", 64'(out_grp), 64'd1);
    chk("R10", "chans", 64'(out_chans), 64'd8);
    chk("R6", "src_base", 64'(src_base), 64'h1000);
    chk("R6", "src_steps", 64'(src_steps), {16'd0, 16'd16, 16'd4, 16'd1});
    chk("R6", "src_counts", 64'(src_counts), {16'd0, 16'd4, 16'd4, 16'd4});
    chk("R7", "src_elems", 64'(src_elems), 64'd64);
    chk("R6", "dst_base", 64'(dst_base), 64'h2000);
    chk("R6", "dst_steps", 64'(dst_steps), {16'd0, 16'd3, 16'd2, 16'd1});
    chk("R7", "dst_elems", 64'(dst_elems), 64'd8);
    @(posedge clk);
    #1;
    chk("R10", "pulse ends", 64'(res_valid), 64'd0);

    // R9 mode reported
    w = base_word();
    w[8*19 +: 8] = 8'hC0;
    w[8*51 +: 8] = 8'h80;
    send_par(w);
    chk("R9", "src_mode", 64'(src_mode), 64'd3);
    chk("R9", "dst_mode", 64'(dst_mode), 64'd2);
    check_result("R9", 13'h1800);

    // R11 back-to-back streamed words
    w = base_word();
    bad = base_word();
    bad[8*33 +: 8] = 8'd0;
    send_beats(w, 0, 15);
    check_result("R11 first", 13'h0000);
    send_beats(bad, 0, 15);
    check_result("R11 second", 13'h0020);
    @(negedge clk);
    beat_valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R11", "idle after stream", 64'(res_valid), 64'd0);

    // R12 parallel word during a stream
    send_beats(w, 0, 6);
    @(negedge clk);
    beat_data = w[32*7 +: 32];
    par_valid = 1'b1;
    par_word  = bad;
    #1;
    chk("R12", "beat_ready while par", 64'(beat_ready), 64'd0);
    @(posedge clk);
    #1;
    par_valid = 1'b0;
    check_result("R12 par word", 13'h0020);
    send_beats(w, 7, 15);
    check_result("R12 resumed stream", 13'h0000);
    @(negedge clk);
    beat_valid = 1'b0;

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule